// File: doc/BRIEF.md
# Reloadable Down-Counter Frequency Divider

This block is a single timer channel that divides a count-clock enable stream by a programmable period. A 16-bit period register feeds a 16-bit down counter. While the channel runs, each count tick lowers the counter by one. When the counter sits at zero, the next tick reloads it from the period register, raises a one-cycle interrupt pulse and inverts the timer output level. With a period value P, the output therefore toggles once every P+1 ticks.

Software starts and stops the channel through single-cycle trigger inputs, which hold no state of their own. A start does not load the counter at once. The load happens on the first count tick after the start, and a mode bit decides whether that load also pulses the interrupt and toggles the output. A stop freezes both the counter and the output level where they are. While the channel is stopped, software may set the output level directly. An output-enable bit selects between the timer level and an external port-hold value on the output pin.

The interface carries no data stream, so every pin is a plain control or status signal, and there is no valid/ready handshake and no back-pressure.

Top module: `fdc_chan`

## Requirements
- R1: A synchronous reset (rst high) clears the counter, period, start-interrupt mode, output level, output enable, running flag and interrupt to 0.
- R2: A start pulse while stopped (and without stop) sets `running` on the next cycle. The counter keeps its old value until the first count tick, which loads the period into it.
- R3: On the first load tick after a start, `irq` pulses and the output level inverts if the start-interrupt mode bit is 1. If the bit is 0, neither happens.
- R4: While running, a tick lowers a non-zero counter by 1, and a tick at zero reloads the period. A period of 0 therefore reloads on every tick.
- R5: Every reload from zero makes `irq` high for exactly the cycle after that tick edge and inverts the output level in the same cycle.
- R6: The period register accepts writes at any time. A new value does not change the counter until the next load.
- R7: A stop pulse clears `running` on the next cycle. The counter and output level then hold, and ticks have no effect while stopped.
- R8: Stop has priority. A stop that arrives together with a start leaves the channel stopped, and a stop that arrives together with a tick blocks that tick.
- R9: A start pulse while running is ignored. The count continues without a reload.
- R10: Writes to the start-interrupt mode bit are ignored while running. Writes to the output level take effect only while stopped.
- R11: `tout` equals the output level when output enable is 1, and equals `port_hold` when it is 0. Output enable can be written at any time.
- R12: `count_out` shows the counter value at all times, whether the channel is running or stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-clock enable pulse from the prescaler |
| start_trig | input | 1 | Start trigger pulse |
| stop_trig | input | 1 | Stop trigger pulse |
| wr_period | input | 1 | Write strobe for the period register |
| period_in | input | 16 | New period value |
| wr_mode | input | 1 | Write strobe for the start-interrupt mode bit |
| mode_in | input | 1 | New start-interrupt mode value |
| wr_level | input | 1 | Write strobe for the output level (honored only while stopped) |
| level_in | input | 1 | New output level |
| wr_oe | input | 1 | Write strobe for the output enable |
| oe_in | input | 1 | New output enable value |
| port_hold | input | 1 | Level driven on the pin while the output is disabled |
| count_out | output | 16 | Current counter value |
| running | output | 1 | Channel running flag |
| irq | output | 1 | One-cycle interrupt pulse |
| tout | output | 1 | Timer output pin level |

## Verification
Two of the channel's functions can fall on the same clock edge: a count tick, which would decrement or reload the counter, and a stop trigger, which freezes it. A start trigger can also meet a stop trigger on one edge. The bench provokes both cases by raising the two inputs in one cycle. It then checks that `running` is 0, that `count_out` still holds the value from before the edge, and that `irq` and `tout` did not move.

// File: rtl/fdc_pkg.sv
`timescale 1ns/1ps
package fdc_pkg;
  // Action taken by the counter on a given clock edge
  typedef enum logic [1:0] {
    STEP_IDLE,  // hold the count
    STEP_LOAD,  // first tick after a start: copy the period in
    STEP_WRAP,  // count is zero: reload the period
    STEP_DEC    // count down by one
  } step_e;
endpackage

// File: rtl/fdc_ctrl.sv
`timescale 1ns/1ps
module fdc_ctrl
  import fdc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start_trig,
  input  logic  stop_trig,
  input  logic  tick,
  input  logic  cnt_zero,
  input  logic  start_irq,
  output logic  running,
  output step_e step,
  output logic  fire
);
  logic first_q;

  always_comb begin
    step = STEP_IDLE;
    if (running && !stop_trig && tick) begin
      if (first_q)       step = STEP_LOAD;
      else if (cnt_zero) step = STEP_WRAP;
      else               step = STEP_DEC;
    end
    fire = (step == STEP_WRAP) || ((step == STEP_LOAD) && start_irq);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      first_q <= 1'b0;
    end else if (stop_trig) begin
      running <= 1'b0;
      first_q <= 1'b0;
    end else if (start_trig && !running) begin
      running <= 1'b1;
      first_q <= 1'b1;
    end else if (step == STEP_LOAD) begin
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/fdc_regs.sv
`timescale 1ns/1ps
module fdc_regs #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         running,
  input  logic         wr_period,
  input  logic [W-1:0] period_in,
  input  logic         wr_mode,
  input  logic         mode_in,
  input  logic         wr_oe,
  input  logic         oe_in,
  output logic [W-1:0] period_q,
  output logic         mode_q,
  output logic         oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      mode_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (wr_period)            period_q <= period_in;
      if (wr_mode && !running)  mode_q   <= mode_in;
      if (wr_oe)                oe_q     <= oe_in;
    end
  end
endmodule

// File: rtl/fdc_count.sv
`timescale 1ns/1ps
module fdc_count
  import fdc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  step_e        step,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt_q,
  output logic         cnt_zero
);
  localparam logic [W-1:0] CNT_ONE = W'(1);

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case (step)
        STEP_LOAD, STEP_WRAP: cnt_q <= period;
        STEP_DEC:             cnt_q <= cnt_q - CNT_ONE;
        default:              cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fdc_out.sv
`timescale 1ns/1ps
module fdc_out (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic running,
  input  logic wr_level,
  input  logic level_in,
  input  logic oe,
  input  logic port_hold,
  output logic lvl_q,
  output logic irq,
  output logic tout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= fire;
      if (fire)                      lvl_q <= ~lvl_q;
      else if (wr_level && !running) lvl_q <= level_in;
    end
  end

  assign tout = oe ? lvl_q : port_hold;
endmodule

// File: rtl/fdc_chan.sv
`timescale 1ns/1ps
module fdc_chan
  import fdc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start_trig,
  input  logic         stop_trig,
  input  logic         wr_period,
  input  logic [W-1:0] period_in,
  input  logic         wr_mode,
  input  logic         mode_in,
  input  logic         wr_level,
  input  logic         level_in,
  input  logic         wr_oe,
  input  logic         oe_in,
  input  logic         port_hold,
  output logic [W-1:0] count_out,
  output logic         running,
  output logic         irq,
  output logic         tout
);
  logic [W-1:0] period_q;
  logic         mode_q;
  logic         oe_q;
  logic         lvl_q;
  logic         cnt_zero;
  logic         fire;
  step_e        step;

  fdc_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .running(running),
    .wr_period(wr_period), .period_in(period_in),
    .wr_mode(wr_mode), .mode_in(mode_in),
    .wr_oe(wr_oe), .oe_in(oe_in),
    .period_q(period_q), .mode_q(mode_q), .oe_q(oe_q)
  );

  fdc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start_trig(start_trig), .stop_trig(stop_trig),
    .tick(tick), .cnt_zero(cnt_zero), .start_irq(mode_q),
    .running(running), .step(step), .fire(fire)
  );

  fdc_count #(.W(W)) u_count (
    .clk(clk), .rst(rst), .step(step), .period(period_q),
    .cnt_q(count_out), .cnt_zero(cnt_zero)
  );

  fdc_out u_out (
    .clk(clk), .rst(rst), .fire(fire), .running(running),
    .wr_level(wr_level), .level_in(level_in), .oe(oe_q),
    .port_hold(port_hold), .lvl_q(lvl_q), .irq(irq), .tout(tout)
  );
endmodule

// File: rtl/fdc_chk.sv
`timescale 1ns/1ps
module fdc_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         start_trig,
  input logic         stop_trig,
  input logic         wr_mode,
  input logic         wr_level,
  input logic         running,
  input logic         irq,
  input logic         mode_q,
  input logic         lvl_q,
  input logic [W-1:0] count_out
);
  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(running && tick && !stop_trig));

  // R5
  level_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> (irq || $past(wr_level && !running)));

  // R7
  frozen_count_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> $stable(count_out));

  // R8
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    stop_trig |=> !running);

  // R2
  start_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (start_trig && !stop_trig) |=> running);

  // R10
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (running && wr_mode) |=> $stable(mode_q));
endmodule

bind fdc_chan fdc_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .start_trig(start_trig),
  .stop_trig(stop_trig), .wr_mode(wr_mode), .wr_level(wr_level),
  .running(running), .irq(irq), .mode_q(mode_q), .lvl_q(lvl_q),
  .count_out(count_out)
);

// File: tb/fdc_chan_tb.sv
`timescale 1ns/1ps
module fdc_chan_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, start_trig = 1'b0, stop_trig = 1'b0;
  logic        wr_period = 1'b0, wr_mode = 1'b0, mode_in = 1'b0;
  logic        wr_level = 1'b0, level_in = 1'b0, wr_oe = 1'b0, oe_in = 1'b0;
  logic        port_hold = 1'b0;
  logic [15:0] period_in = '0;
  logic [15:0] count_out;
  logic        running, irq, tout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fdc_chan u_dut (
    .clk(clk), .rst(rst), .tick(tick), .start_trig(start_trig),
    .stop_trig(stop_trig), .wr_period(wr_period), .period_in(period_in),
    .wr_mode(wr_mode), .mode_in(mode_in), .wr_level(wr_level),
    .level_in(level_in), .wr_oe(wr_oe), .oe_in(oe_in),
    .port_hold(port_hold), .count_out(count_out), .running(running),
    .irq(irq), .tout(tout)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1; cyc(n); tick = 1'b0;
  endtask

  task automatic do_start();
    start_trig = 1'b1; cyc(); start_trig = 1'b0;
  endtask

  task automatic do_stop();
    stop_trig = 1'b1; cyc(); stop_trig = 1'b0;
  endtask

  task automatic set_period(input logic [15:0] v);
    period_in = v; wr_period = 1'b1; cyc(); wr_period = 1'b0;
  endtask

  task automatic set_mode(input logic v);
    mode_in = v; wr_mode = 1'b1; cyc(); wr_mode = 1'b0;
  endtask

  task automatic set_level(input logic v);
    level_in = v; wr_level = 1'b1; cyc(); wr_level = 1'b0;
  endtask

  task automatic set_oe(input logic v);
    oe_in = v; wr_oe = 1'b1; cyc(); wr_oe = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1", "count after reset", count_out, 0);
    chk("R1", "running after reset", running, 0);
    chk("R1", "irq after reset", irq, 0);
    port_hold = 1'b1; #1;
    chk("R1", "pin follows hold with oe cleared", tout, 1);
    port_hold = 1'b0; #1;
  endtask

  task automatic t_basic_divide();
    set_oe(1'b1);
    set_period(16'd5);
    do_start();
    chk("R2", "running after start", running, 1);
    chk("R2", "no load before first tick", count_out, 0);
    ticks(1);
    chk("R2", "first tick loads period", count_out, 5);
    chk("R3", "mode 0 no irq at load", irq, 0);
    chk("R3", "mode 0 no toggle at load", tout, 0);
    ticks(5);
    chk("R4", "count down to zero", count_out, 0);
    chk("R4", "no irq while decrementing", irq, 0);
    ticks(1);
    chk("R4", "reload from zero", count_out, 5);
    chk("R5", "irq on reload", irq, 1);
    chk("R5", "toggle on reload", tout, 1);
    cyc();
    chk("R5", "irq lasts one cycle", irq, 0);
  endtask

  task automatic t_start_irq_mode();
    do_stop();
    set_mode(1'b1);
    set_period(16'd3);
    do_start();
    chk("R2", "old count kept until tick", count_out, 5);
    ticks(1);
    chk("R3", "mode 1 load value", count_out, 3);
    chk("R3", "mode 1 irq at load", irq, 1);
    chk("R3", "mode 1 toggle at load", tout, 0);
  endtask

  task automatic t_period_rewrite();
    ticks(1);
    set_period(16'd7);
    chk("R6", "period write leaves count", count_out, 2);
    ticks(2);
    chk("R6", "old count runs out", count_out, 0);
    ticks(1);
    chk("R6", "new period used at reload", count_out, 7);
    chk("R6", "irq at reload", irq, 1);
    chk("R6", "toggle at reload", tout, 1);
  endtask

  task automatic t_restart_ignored();
    do_start();
    chk("R9", "still running", running, 1);
    chk("R9", "count unchanged by start", count_out, 7);
    ticks(1);
    chk("R9", "continues down, no reload", count_out, 6);
    chk("R9", "no irq from ignored start", irq, 0);
  endtask

  task automatic t_mode_lock();
    set_mode(1'b0);
    do_stop();
    do_start();
    ticks(1);
    chk("R10", "mode write while running ignored", irq, 1);
    chk("R10", "load value", count_out, 7);
    chk("R10", "toggle at load kept mode 1", tout, 0);
    set_level(1'b1);
    chk("R10", "level write while running ignored", tout, 0);
  endtask

  task automatic t_stop_hold();
    do_stop();
    chk("R7", "running cleared", running, 0);
    ticks(3);
    chk("R7", "count frozen", count_out, 7);
    chk("R12", "count readable while stopped", count_out, 7);
    chk("R7", "level held", tout, 0);
    chk("R7", "no irq while stopped", irq, 0);
    set_level(1'b1);
    chk("R10", "level write while stopped", tout, 1);
  endtask

  task automatic t_pin_select();
    set_oe(1'b0);
    port_hold = 1'b0; #1;
    chk("R11", "pin shows hold 0", tout, 0);
    port_hold = 1'b1; #1;
    chk("R11", "pin shows hold 1", tout, 1);
    port_hold = 1'b0;
    set_oe(1'b1);
    chk("R11", "pin shows level again", tout, 1);
  endtask

  task automatic t_collisions();
    set_mode(1'b0);
    start_trig = 1'b1; stop_trig = 1'b1; cyc();
    start_trig = 1'b0; stop_trig = 1'b0;
    chk("R8", "stop beats start", running, 0);
    do_start();
    ticks(2);
    chk("R12", "count readable while running", count_out, 6);
    stop_trig = 1'b1; tick = 1'b1; cyc();
    stop_trig = 1'b0; tick = 1'b0;
    chk("R8", "stop stops", running, 0);
    chk("R8", "tick blocked by stop", count_out, 6);
    chk("R8", "no irq on blocked tick", irq, 0);
    chk("R8", "level unchanged", tout, 1);
  endtask

  task automatic t_zero_period();
    set_period(16'd0);
    do_start();
    ticks(1);
    chk("R4", "zero period load", count_out, 0);
    chk("R4", "no irq at load in mode 0", irq, 0);
    ticks(1);
    chk("R4", "zero period irq each tick", irq, 1);
    chk("R4", "toggle after one tick", tout, 0);
    ticks(1);
    chk("R4", "second consecutive irq", irq, 1);
    chk("R4", "toggle again", tout, 1);
    cyc();
    do_stop();
  endtask

  task automatic t_reset_midrun();
    set_period(16'd9);
    do_start();
    ticks(3);
    rst = 1'b1; cyc(2); rst = 1'b0;
    chk("R1", "count cleared", count_out, 0);
    chk("R1", "running cleared", running, 0);
    chk("R1", "irq cleared", irq, 0);
    port_hold = 1'b1; #1;
    chk("R1", "oe cleared", tout, 1);
    port_hold = 1'b0;
    set_oe(1'b1);
    chk("R1", "level cleared", tout, 0);
    do_start();
    ticks(1);
    chk("R1", "period cleared", count_out, 0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc();
    t_reset_state();
    t_basic_divide();
    t_start_irq_mode();
    t_period_rewrite();
    t_restart_ignored();
    t_mode_lock();
    t_stop_hold();
    t_pin_select();
    t_collisions();
    t_zero_period();
    t_reset_midrun();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule